// File: doc/BRIEF.md
# 32-bit Lookahead ALU with Logarithmic Shifter

This block is the purely combinational arithmetic unit of a small load/store processor. It takes two 32-bit operands and a 4-bit function code, and returns a 32-bit result in the same cycle. It also returns a carry-out flag and a signed-overflow flag.

Addition and subtraction share one adder. The adder is made of eight 4-bit slices. Each slice reports a group propagate and a group generate signal. A second lookahead level turns these into slice carry-ins inside each 16-bit half. A third level joins the two halves. Subtraction feeds the inverted second operand into the adder with a carry-in of one. The signed comparisons reuse this difference.

Shifts do not use the adder. They go through a five-stage shifter whose stages move the data by 1, 2, 4, 8 and 16 places. A final selector picks the output for the requested function.

Function codes: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 NOT, 6 shift left logical, 7 shift right logical, 8 shift right arithmetic, 9 set-equal, 10 set-not-equal, 11 set-less-than, 12 set-greater-than, 13 set-less-or-equal, 14 set-greater-or-equal, 15 unused.

Top module: `lookahead_alu`

## Requirements
- R1: Code 0 gives y = (a + b) mod 2^32, and cout is the carry out of bit 31.
- R2: Code 1 gives y = (a - b) mod 2^32. For this code, cout is the carry out of a + ~b + 1, which is 1 exactly when a >= b as unsigned numbers.
- R3: For codes 0 and 1, ovf is 1 exactly when the true signed result does not fit in 32 bits. For every other code, cout and ovf are both 0.
- R4: Codes 2, 3, 4 and 5 give a AND b, a OR b, a XOR b, and the bitwise inverse of a, respectively.
- R5: Codes 9 to 14 compare a with b as signed two's-complement numbers: equal, not equal, less, greater, less-or-equal, greater-or-equal. The result is 32'd1 when the relation holds and 32'd0 otherwise.
- R6: Code 6 shifts a left, code 7 shifts a right with zero fill, and code 8 shifts a right with copies of a[31]. The shift distance is b[4:0], and b[31:5] has no effect on the result.
- R7: Code 15 gives y = 0.
- R8: A carry rippled into bit 0 reaches every slice and both halves. For example, 0xFFFFFFFF + 1 gives y = 0 and cout = 1, and 0x0000FFFF + 1 gives 0x00010000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand; also the data that is shifted |
| b | input | 32 | Second operand; its low 5 bits are the shift distance |
| op | input | 4 | Function code |
| y | output | 32 | Result |
| cout | output | 1 | Adder carry out for add and subtract |
| ovf | output | 1 | Signed overflow for add and subtract |

## Verification
Uniform random operand pairs exercise every function code. They mostly separate the functions from one another and catch wiring slips in the logic and shift paths. Directed patterns cover the cases random data rarely reaches:
- carries that ripple across slice and half boundaries, such as all-ones plus one and 0x0000FFFF plus one, which expose a wrong lookahead term at one level;
- the most negative and most positive values, which decide overflow and the signed-versus-unsigned ordering of the comparisons;
- equal operands, which split the strict comparisons from the inclusive ones;
- shift distances of 0 and 31, and values with high garbage in b[31:5], which check that every stage of the shifter is used and that only the low five bits count.

// File: rtl/lookahead_alu.sv
module lookahead_alu (
  input  logic [31:0] a,
  input  logic [31:0] b,
  input  logic [3:0]  op,
  output logic [31:0] y,
  output logic        cout,
  output logic        ovf
);
  localparam int W      = 32;
  localparam int SLICE  = 4;
  localparam int NSLICE = W / SLICE;
  localparam int SHB    = $clog2(W);

  localparam logic [3:0] F_ADD = 4'd0,  F_SUB = 4'd1,  F_AND = 4'd2,  F_OR  = 4'd3;
  localparam logic [3:0] F_XOR = 4'd4,  F_NOT = 4'd5,  F_SLL = 4'd6,  F_SRL = 4'd7;
  localparam logic [3:0] F_SRA = 4'd8,  F_SEQ = 4'd9,  F_SNE = 4'd10, F_SLT = 4'd11;
  localparam logic [3:0] F_SGT = 4'd12, F_SLE = 4'd13, F_SGE = 4'd14;

  logic          sub;
  logic [W-1:0]  bx, p, g, cb, sum;
  logic [NSLICE-1:0] gp, gg, cs;
  logic [1:0]    hp, hg, ch;
  logic          c_top, v_raw;

  assign sub = (op != F_ADD);
  assign bx  = sub ? ~b : b;
  assign p   = a ^ bx;
  assign g   = a & bx;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    localparam int B0 = s * SLICE;
    assign cb[B0]   = cs[s];
    assign cb[B0+1] = g[B0] | (p[B0] & cs[s]);
    assign cb[B0+2] = g[B0+1] | (p[B0+1] & g[B0]) | (p[B0+1] & p[B0] & cs[s]);
    assign cb[B0+3] = g[B0+2] | (p[B0+2] & g[B0+1]) | (p[B0+2] & p[B0+1] & g[B0])
                    | (p[B0+2] & p[B0+1] & p[B0] & cs[s]);
    assign gp[s] = &p[B0 +: SLICE];
    assign gg[s] = g[B0+3] | (p[B0+3] & g[B0+2]) | (p[B0+3] & p[B0+2] & g[B0+1])
                 | (p[B0+3] & p[B0+2] & p[B0+1] & g[B0]);
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam int K = h * 4;
    assign cs[K]   = ch[h];
    assign cs[K+1] = gg[K] | (gp[K] & ch[h]);
    assign cs[K+2] = gg[K+1] | (gp[K+1] & gg[K]) | (gp[K+1] & gp[K] & ch[h]);
    assign cs[K+3] = gg[K+2] | (gp[K+2] & gg[K+1]) | (gp[K+2] & gp[K+1] & gg[K])
                   | (gp[K+2] & gp[K+1] & gp[K] & ch[h]);
    assign hp[h] = &gp[K +: 4];
    assign hg[h] = gg[K+3] | (gp[K+3] & gg[K+2]) | (gp[K+3] & gp[K+2] & gg[K+1])
                 | (gp[K+3] & gp[K+2] & gp[K+1] & gg[K]);
  end

  assign ch[0] = sub;
  assign ch[1] = hg[0] | (hp[0] & sub);
  assign c_top = hg[1] | (hp[1] & hg[0]) | (hp[1] & hp[0] & sub);
  assign sum   = p ^ cb;
  assign v_raw = (a[W-1] == bx[W-1]) && (sum[W-1] != a[W-1]);

  logic          is_eq, is_lt;
  assign is_eq = (sum == '0);
  assign is_lt = sum[W-1] ^ v_raw;

  logic              sh_left, fill;
  logic [SHB-1:0]    amt;
  logic [W-1:0]      stg [0:SHB];
  logic [W-1:0]      a_rev, sh_out, sh_rev;

  assign sh_left = (op == F_SLL);
  assign fill    = (op == F_SRA) & a[W-1];
  assign amt     = b[SHB-1:0];

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign a_rev[i]  = a[W-1-i];
    assign sh_rev[i] = stg[SHB][W-1-i];
  end

  assign stg[0] = sh_left ? a_rev : a;
  for (genvar k = 0; k < SHB; k++) begin : g_stage
    localparam int D = 1 << k;
    assign stg[k+1] = amt[k] ? {{D{fill}}, stg[k][W-1:D]} : stg[k];
  end
  assign sh_out = sh_left ? sh_rev : stg[SHB];

  always_comb begin
    y    = '0;
    cout = 1'b0;
    ovf  = 1'b0;
    case (op)
      F_ADD, F_SUB: begin y = sum; cout = c_top; ovf = v_raw; end
      F_AND: y = a & b;
      F_OR:  y = a | b;
      F_XOR: y = a ^ b;
      F_NOT: y = ~a;
      F_SLL, F_SRL, F_SRA: y = sh_out;
      F_SEQ: y = {{W-1{1'b0}}, is_eq};
      F_SNE: y = {{W-1{1'b0}}, ~is_eq};
      F_SLT: y = {{W-1{1'b0}}, is_lt};
      F_SGT: y = {{W-1{1'b0}}, ~is_lt & ~is_eq};
      F_SLE: y = {{W-1{1'b0}}, is_lt | is_eq};
      F_SGE: y = {{W-1{1'b0}}, ~is_lt};
      default: y = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({a, b, op})) begin
      assert_cla_sum_R8: assert ({c_top, sum} == ({1'b0, a} + {1'b0, bx} + {{W{1'b0}}, sub}))
        else $error("lookahead sum disagrees with plain addition");
      if (op == F_ADD)
        assert_add_R1: assert ({cout, y} == ({1'b0, a} + {1'b0, b}))
          else $error("add result wrong");
      if (op == F_SLL)
        assert_shl_R6: assert (y == (a << b[4:0])) else $error("left shift wrong");
      if (op >= F_SEQ && op <= F_SGE)
        assert_cmp_R5: assert (y[W-1:1] == '0) else $error("compare upper bits set");
      if (op > F_SUB)
        assert_no_flags_R3: assert (!cout && !ovf) else $error("flags outside add/sub");
      if (op == 4'd15)
        assert_unused_R7: assert (y == '0) else $error("unused code nonzero");
    end
  end
endmodule

// File: tb/lookahead_alu_bench.sv
module lookahead_alu_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] a, b, y;
  logic [3:0]  op;
  logic        cout, ovf;
  int checks = 0, errors = 0;
  bit finished = 0;

  lookahead_alu u_lookahead_alu (.a(a), .b(b), .op(op), .y(y), .cout(cout), .ovf(ovf));

  function automatic string req_of(input logic [3:0] f);
    case (f)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4, 4'd5: return "R4";
      4'd6, 4'd7, 4'd8: return "R6";
      4'd15: return "R7";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [33:0] model(input logic [3:0] f, input logic [31:0] x, input logic [31:0] z);
    logic [32:0] r;
    logic [32:0] sx;
    logic [31:0] res;
    logic c, v;
    c = 0; v = 0; res = 0;
    case (f)
      4'd0: begin
        r = {1'b0, x} + {1'b0, z}; res = r[31:0]; c = r[32];
        sx = {x[31], x} + {z[31], z}; v = sx[32] != sx[31];
      end
      4'd1: begin
        res = x - z; c = (x >= z);
        sx = {x[31], x} - {z[31], z}; v = sx[32] != sx[31];
      end
      4'd2: res = x & z;
      4'd3: res = x | z;
      4'd4: res = x ^ z;
      4'd5: res = ~x;
      4'd6: res = x << z[4:0];
      4'd7: res = x >> z[4:0];
      4'd8: res = $unsigned($signed(x) >>> z[4:0]);
      4'd9:  res = {31'd0, x == z};
      4'd10: res = {31'd0, x != z};
      4'd11: res = {31'd0, $signed(x) <  $signed(z)};
      4'd12: res = {31'd0, $signed(x) >  $signed(z)};
      4'd13: res = {31'd0, $signed(x) <= $signed(z)};
      4'd14: res = {31'd0, $signed(x) >= $signed(z)};
      default: res = 0;
    endcase
    return {v, c, res};
  endfunction

  task automatic run(input logic [3:0] f, input logic [31:0] x, input logic [31:0] z, input string tag);
    logic [33:0] exp;
    a = x; b = z; op = f;
    #5;
    exp = model(f, x, z);
    checks++;
    if ({ovf, cout, y} !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h actual y=%h c=%b v=%b expected y=%h c=%b v=%b",
               tag, f, x, z, y, cout, ovf, exp[31:0], exp[32], exp[33]);
    end
    #5;
  endtask

  initial begin
    #(150000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    a = 0; b = 0; op = 0;
    #2;
    run(4'd0, 32'd0, 32'd0, "R1 idle zero");
    run(4'd0, 32'hFFFF_FFFF, 32'd1, "R8 full ripple");
    run(4'd0, 32'h0000_FFFF, 32'd1, "R8 half boundary");
    run(4'd0, 32'h0000_000F, 32'd1, "R8 slice boundary");
    run(4'd0, 32'h7FFF_FFFF, 32'd1, "R3 positive overflow");
    run(4'd0, 32'h8000_0000, 32'h8000_0000, "R3 negative overflow");
    run(4'd1, 32'h8000_0000, 32'd1, "R3 sub overflow");
    run(4'd1, 32'd5, 32'd5, "R2 equal sub");
    run(4'd1, 32'd3, 32'd7, "R2 borrow");
    run(4'd2, 32'hF0F0_F0F0, 32'hFF00_FF00, "R4 and");
    run(4'd5, 32'h1234_5678, 32'hFFFF_FFFF, "R4 not");
    run(4'd11, 32'h8000_0000, 32'h7FFF_FFFF, "R5 signed lt");
    run(4'd12, 32'h8000_0000, 32'h7FFF_FFFF, "R5 signed gt");
    run(4'd13, 32'd9, 32'd9, "R5 le equal");
    run(4'd11, 32'd9, 32'd9, "R5 lt equal");
    run(4'd14, 32'hFFFF_FFFF, 32'd0, "R5 ge negative");
    run(4'd6, 32'h8000_0001, 32'hFFFF_FFE0, "R6 zero distance high junk");
    run(4'd6, 32'h0000_0001, 32'd31, "R6 left 31");
    run(4'd7, 32'h8000_0000, 32'd31, "R6 right 31");
    run(4'd8, 32'h8000_0000, 32'hABCD_EF3F, "R6 arith 31 junk");
    run(4'd8, 32'h4000_0000, 32'd30, "R6 arith positive");
    run(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7 unused");
    run(4'd3, 32'hFFFF_FFFF, 32'd1, "R3 flags zero on or");
    for (int n = 0; n < 2000; n++) begin
      for (int f = 0; f < 16; f++) begin
        run(4'(f), $urandom, $urandom, req_of(4'(f)));
      end
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule